// File: doc/BRIEF.md
# Precise Pipeline Exception Controller

This block keeps exceptions precise in an in-order five-stage pipeline. Faults can be raised in the fetch, decode, execute and memory stages. Each fault is folded into a small status word that travels with its instruction, one register stage at a time. Nothing is acted on until the instruction reaches the commit point at the memory stage. An instruction that faults early but is younger than a faulting older instruction therefore never wins. Faults raised together in one cycle resolve in program order.

When the instruction at the commit point carries a fault, the block acts in one cycle. It flushes that instruction and every younger stage, and it redirects fetch. The target is either one fixed handler entry or, in vectored mode, a table base plus an offset scaled from the cause. The faulting PC and the cause code are latched into registers that hold until the next exception. The block keeps its own liveness bit per stage, so flushed slots act as bubbles even if the pipeline's valid inputs lag by a cycle.

Top module: `precise_exc_ctrl`

## Requirements
- R1: After reset, flush is 0, redirect_valid is 0, and epc and cause are both 0.
- R2: Fetch faults use if_fault bit 0 for misaligned (cause 0), bit 1 for protection (cause 1) and bit 2 for page fault (cause 12). When several bits are set, the lowest cause number is recorded.
- R3: An illegal opcode in decode records cause 2. An arithmetic overflow in execute records cause 4.
- R4: Memory-stage faults use mem_fault bit 0 for protection (cause 5), bit 1 for misaligned (cause 6) and bit 2 for page fault (cause 13). When several bits are set, the lowest cause number is recorded.
- R5: An exception is taken only for a live, valid instruction in the memory stage whose status holds a fault. If a younger instruction faulted first, the older instruction's fault is still the one taken.
- R6: Once an instruction has a fault recorded, faults it raises in later stages are ignored, and its first cause is the one reported.
- R7: On the edge that ends a taking cycle, epc loads mem_pc and cause loads the recorded code. At all other edges both hold their values.
- R8: In a taking cycle, all four flush bits are set (bit 0 fetch through bit 3 memory), together with redirect_valid. Flushed instructions become bubbles, so the next cycle never takes an exception.
- R9: With vec_mode low, redirect_pc is the handler address 0x0000_0000_1C09_0000.
- R10: With vec_mode high, redirect_pc is vec_base plus the cause times 4.
- R11: A stage whose valid input is low is a bubble. Its fault inputs record nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Fetch stage holds an instruction |
| if_fault | input | 3 | Fetch faults: [0] misaligned, [1] protection, [2] page fault |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_illegal | input | 1 | Illegal or undefined opcode |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_overflow | input | 1 | Arithmetic overflow |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_fault | input | 3 | Data faults: [0] protection, [1] misaligned, [2] page fault |
| mem_pc | input | XLEN | PC of the memory-stage instruction |
| vec_mode | input | 1 | Select vectored redirect |
| vec_base | input | XLEN | Vector table base |
| flush | output | 4 | Bubble request per stage, [0] fetch to [3] memory |
| redirect_valid | output | 1 | Load redirect_pc into the fetch PC |
| redirect_pc | output | XLEN | Handler target |
| epc | output | XLEN | PC of the last excepting instruction |
| cause | output | 4 | Cause of the last exception |

## Verification
A corrupted status word in a middle stage shows at the ports once the instruction reaches the memory stage, up to three cycles later. It appears as a missing or spurious redirect, or as a wrong cause, visible at once in vectored mode and on epc/cause one edge after the take. A liveness bit that is not cleared shows as a second redirect in the cycle right after a flush. A wrong priority between stages shows on the first random overlap of faults between an older and a younger instruction.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int CAUSE_W = 4;
  typedef logic [CAUSE_W-1:0] cause_t;

  localparam cause_t C_FETCH_MISAL = 4'd0;
  localparam cause_t C_FETCH_PROT  = 4'd1;
  localparam cause_t C_ILLEGAL     = 4'd2;
  localparam cause_t C_OVERFLOW    = 4'd4;
  localparam cause_t C_DATA_PROT   = 4'd5;
  localparam cause_t C_DATA_MISAL  = 4'd6;
  localparam cause_t C_FETCH_PAGE  = 4'd12;
  localparam cause_t C_DATA_PAGE   = 4'd13;

  // live: slot holds a real instruction; hit: a fault is recorded
  typedef struct packed {
    logic   live;
    logic   hit;
    cause_t code;
  } stat_t;

  // lowest cause number wins within the fetch stage
  function automatic stat_t enc_fetch(input logic [2:0] f);
    stat_t s;
    s = '0;
    s.hit = |f;
    if (f[0])      s.code = C_FETCH_MISAL;
    else if (f[1]) s.code = C_FETCH_PROT;
    else if (f[2]) s.code = C_FETCH_PAGE;
    return s;
  endfunction

  function automatic stat_t enc_data(input logic [2:0] f);
    stat_t s;
    s = '0;
    s.hit = |f;
    if (f[0])      s.code = C_DATA_PROT;
    else if (f[1]) s.code = C_DATA_MISAL;
    else if (f[2]) s.code = C_DATA_PAGE;
    return s;
  endfunction

  function automatic stat_t enc_single(input logic f, input cause_t c);
    stat_t s;
    s = '0;
    s.hit  = f;
    s.code = c;
    return s;
  endfunction
endpackage

// File: rtl/exc_stage_merge.sv
module exc_stage_merge
  import exc_ctrl_pkg::*;
#(
  parameter int STAGE = 0,
  parameter int FW    = 3
) (
  input  stat_t           carry_in,
  input  logic            stage_valid,
  input  logic [FW-1:0]   flt,
  output stat_t           stat_out
);
  stat_t local_s;
  logic  slot_live;

  generate
    if (STAGE == 0) begin : g_fetch
      assign local_s   = enc_fetch(flt[2:0]);
      assign slot_live = stage_valid;
    end else if (STAGE == 1) begin : g_decode
      assign local_s   = enc_single(flt[0], C_ILLEGAL);
      assign slot_live = stage_valid & carry_in.live;
    end else if (STAGE == 2) begin : g_exec
      assign local_s   = enc_single(flt[0], C_OVERFLOW);
      assign slot_live = stage_valid & carry_in.live;
    end else begin : g_mem
      assign local_s   = enc_data(flt[2:0]);
      assign slot_live = stage_valid & carry_in.live;
    end
  endgenerate

  // the first recorded fault sticks; later ones are dropped
  always_comb begin
    stat_out.live = slot_live;
    stat_out.hit  = slot_live & (carry_in.hit | local_s.hit);
    stat_out.code = carry_in.hit ? carry_in.code : local_s.code;
  end
endmodule

// File: rtl/exc_status_pipe.sv
module exc_status_pipe
  import exc_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  kill,
  input  stat_t from_if,
  input  stat_t from_id,
  input  stat_t from_ex,
  output stat_t at_id,
  output stat_t at_ex,
  output stat_t at_mem
);
  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      at_id  <= '0;
      at_ex  <= '0;
      at_mem <= '0;
    end else begin
      at_id  <= from_if;
      at_ex  <= from_id;
      at_mem <= from_ex;
    end
  end
endmodule

// File: rtl/exc_commit.sv
module exc_commit
  import exc_ctrl_pkg::*;
#(
  parameter int          XLEN         = 64,
  parameter logic [63:0] HANDLER_ADDR = 64'h0000_0000_1C09_0000,
  parameter int          VEC_SHIFT    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  stat_t           mem_stat,
  input  logic [XLEN-1:0] mem_pc,
  input  logic            vec_mode,
  input  logic [XLEN-1:0] vec_base,
  output logic            take,
  output cause_t          take_cause,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] epc_q,
  output cause_t          cause_q
);
  function automatic logic [XLEN-1:0] vec_target(input logic [XLEN-1:0] base,
                                                 input cause_t c);
    return base + (XLEN'(c) << VEC_SHIFT);
  endfunction

  assign take       = mem_stat.live & mem_stat.hit;
  assign take_cause = mem_stat.code;
  assign target     = vec_mode ? vec_target(vec_base, mem_stat.code)
                               : HANDLER_ADDR[XLEN-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (take) begin
      epc_q   <= mem_pc;
      cause_q <= mem_stat.code;
    end
  end
endmodule

// File: rtl/precise_exc_ctrl.sv
module precise_exc_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int          XLEN         = 64,
  parameter logic [63:0] HANDLER_ADDR = 64'h0000_0000_1C09_0000,
  parameter int          VEC_SHIFT    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_valid,
  input  logic [2:0]      if_fault,
  input  logic            id_valid,
  input  logic            id_illegal,
  input  logic            ex_valid,
  input  logic            ex_overflow,
  input  logic            mem_valid,
  input  logic [2:0]      mem_fault,
  input  logic [XLEN-1:0] mem_pc,
  input  logic            vec_mode,
  input  logic [XLEN-1:0] vec_base,
  output logic [3:0]      flush,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] epc,
  output logic [3:0]      cause
);
  localparam int NSTG = 4;

  stat_t q_id, q_ex, q_mem;
  stat_t e_if, e_id, e_ex, e_mem;
  logic   commit_take;
  cause_t commit_cause;

  exc_stage_merge #(.STAGE(0), .FW(3)) u_m_if (
    .carry_in('0), .stage_valid(if_valid), .flt(if_fault), .stat_out(e_if));
  exc_stage_merge #(.STAGE(1), .FW(1)) u_m_id (
    .carry_in(q_id), .stage_valid(id_valid), .flt(id_illegal), .stat_out(e_id));
  exc_stage_merge #(.STAGE(2), .FW(1)) u_m_ex (
    .carry_in(q_ex), .stage_valid(ex_valid), .flt(ex_overflow), .stat_out(e_ex));
  exc_stage_merge #(.STAGE(3), .FW(3)) u_m_mem (
    .carry_in(q_mem), .stage_valid(mem_valid), .flt(mem_fault), .stat_out(e_mem));

  exc_status_pipe u_pipe (
    .clk(clk), .rst_n(rst_n), .kill(commit_take),
    .from_if(e_if), .from_id(e_id), .from_ex(e_ex),
    .at_id(q_id), .at_ex(q_ex), .at_mem(q_mem));

  exc_commit #(.XLEN(XLEN), .HANDLER_ADDR(HANDLER_ADDR), .VEC_SHIFT(VEC_SHIFT)) u_commit (
    .clk(clk), .rst_n(rst_n), .mem_stat(e_mem), .mem_pc(mem_pc),
    .vec_mode(vec_mode), .vec_base(vec_base),
    .take(commit_take), .take_cause(commit_cause),
    .target(redirect_pc), .epc_q(epc), .cause_q(cause));

  assign flush          = {NSTG{commit_take}};
  assign redirect_valid = commit_take;
endmodule

// File: rtl/exc_ctrl_checker.sv
module exc_ctrl_checker #(
  parameter int          XLEN         = 64,
  parameter logic [63:0] HANDLER_ADDR = 64'h0000_0000_1C09_0000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_valid,
  input logic [XLEN-1:0] mem_pc,
  input logic            vec_mode,
  input logic [3:0]      flush,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic [XLEN-1:0] epc,
  input logic [3:0]      cause,
  input logic [3:0]      take_cause
);
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

  assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid |-> flush == 4'hF) and (flush != 4'h0 |-> redirect_valid));

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (epc == $past(mem_pc)) && (cause == $past(take_cause)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_valid |=> $stable(epc) && $stable(cause));

  assert_fixed_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !vec_mode) |-> redirect_pc == HANDLER_ADDR[XLEN-1:0]);

  assert_legal_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> take_cause inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd12, 4'd13});

  assert_commit_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> mem_valid);
endmodule

bind precise_exc_ctrl exc_ctrl_checker #(.XLEN(XLEN), .HANDLER_ADDR(HANDLER_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_pc(mem_pc),
  .vec_mode(vec_mode), .flush(flush), .redirect_valid(redirect_valid),
  .redirect_pc(redirect_pc), .epc(epc), .cause(cause), .take_cause(commit_cause));

// File: tb/tb_precise_exc_ctrl.sv
module tb_precise_exc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] HANDLER = 64'h0000_0000_1C09_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_valid, id_valid, ex_valid, mem_valid;
  logic [2:0] if_fault, mem_fault;
  logic id_illegal, ex_overflow, vec_mode;
  logic [63:0] mem_pc, vec_base;
  logic [3:0] flush, cause;
  logic redirect_valid;
  logic [63:0] redirect_pc, epc;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model state for decode, execute, memory slots
  int m_live[1:3], m_hit[1:3], m_code[1:3];
  logic [63:0] exp_epc = '0;
  logic [3:0]  exp_cause = '0;
  logic obs_rv;
  logic [63:0] obs_rpc;

  always #(CLK_PERIOD/2) clk = ~clk;

  precise_exc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_fault(if_fault),
    .id_valid(id_valid), .id_illegal(id_illegal), .ex_valid(ex_valid),
    .ex_overflow(ex_overflow), .mem_valid(mem_valid), .mem_fault(mem_fault),
    .mem_pc(mem_pc), .vec_mode(vec_mode), .vec_base(vec_base),
    .flush(flush), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .epc(epc), .cause(cause));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // does cause number c belong to the given stage fault bits
  function automatic bit has_code(input int stg, input int c, input logic [2:0] b);
    case (stg)
      0: return (c == 0 && b[0]) || (c == 1 && b[1]) || (c == 12 && b[2]);
      1: return c == 2 && b[0];
      2: return c == 4 && b[0];
      default: return (c == 5 && b[0]) || (c == 6 && b[1]) || (c == 13 && b[2]);
    endcase
  endfunction

  function automatic int first_code(input int stg, input logic [2:0] b);
    for (int c = 0; c < 16; c++) if (has_code(stg, c, b)) return c;
    return -1;
  endfunction

  task automatic step(input logic [3:0] vv, input logic [2:0] fi, input logic fd,
                      input logic fe, input logic [2:0] fm, input logic [63:0] pc,
                      input logic vm, input logic [63:0] vb);
    int e_live[0:3], e_hit[0:3], e_code[0:3];
    logic [2:0] bits[0:3];
    bit take;
    logic [63:0] tgt;
    @(negedge clk);
    check(epc == exp_epc, "R7 epc", epc, exp_epc);
    check(cause == exp_cause, "R7 cause", 64'(cause), 64'(exp_cause));
    {mem_valid, ex_valid, id_valid, if_valid} = vv;
    if_fault = fi; id_illegal = fd; ex_overflow = fe; mem_fault = fm;
    mem_pc = pc; vec_mode = vm; vec_base = vb;
    #1;
    bits[0] = fi; bits[1] = {2'b00, fd}; bits[2] = {2'b00, fe}; bits[3] = fm;
    for (int s = 0; s < 4; s++) begin
      int lc, bh;
      lc = first_code(s, bits[s]);
      bh = (s == 0) ? 0 : m_hit[s];
      e_live[s] = (vv[s] && (s == 0 || m_live[s] != 0)) ? 1 : 0;
      e_hit[s]  = (e_live[s] != 0 && (bh != 0 || lc >= 0)) ? 1 : 0;
      e_code[s] = (bh != 0) ? m_code[s] : lc;
    end
    take = e_live[3] != 0 && e_hit[3] != 0;
    tgt = vm ? vb + 64'(e_code[3]) * 64'd4 : HANDLER;
    obs_rv = redirect_valid; obs_rpc = redirect_pc;
    check(redirect_valid == take, "R5 take", 64'(redirect_valid), 64'(take));
    check(flush == (take ? 4'hF : 4'h0), "R8 flush", 64'(flush), take ? 64'hF : 64'h0);
    if (take)
      check(redirect_pc == tgt, vm ? "R10 vector target" : "R9 handler target",
            redirect_pc, tgt);
    if (take) begin
      for (int s = 1; s < 4; s++) begin m_live[s] = 0; m_hit[s] = 0; m_code[s] = 0; end
      exp_epc = pc; exp_cause = 4'(e_code[3]);
    end else begin
      for (int s = 3; s >= 1; s--) begin
        m_live[s] = e_live[s-1]; m_hit[s] = e_hit[s-1]; m_code[s] = e_code[s-1];
      end
    end
  endtask

  task automatic clean(input int n);
    for (int i = 0; i < n; i++) step(4'hF, 3'b0, 1'b0, 1'b0, 3'b0, 64'h100 + 64'(i), 1'b1, 64'h0);
  endtask

  // one instruction carries the given faults through its four stages
  task automatic single(input logic [2:0] fi, input logic fd, input logic fe,
                        input logic [2:0] fm, input bit exp_take, input int exp_c,
                        input string req);
    clean(5);
    step(4'hF, fi, 1'b0, 1'b0, 3'b0, 64'h200, 1'b1, 64'h0);
    step(4'hF, 3'b0, fd, 1'b0, 3'b0, 64'h204, 1'b1, 64'h0);
    step(4'hF, 3'b0, 1'b0, fe, 3'b0, 64'h208, 1'b1, 64'h0);
    step(4'hF, 3'b0, 1'b0, 1'b0, fm, 64'h20C, 1'b1, 64'h0);
    check(obs_rv == exp_take, req, 64'(obs_rv), 64'(exp_take));
    if (exp_take) check(obs_rpc == 64'(exp_c) * 64'd4, req, obs_rpc, 64'(exp_c) * 64'd4);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 1; s < 4; s++) begin m_live[s] = 0; m_hit[s] = 0; m_code[s] = 0; end
    {if_valid, id_valid, ex_valid, mem_valid} = '0;
    if_fault = '0; id_illegal = 0; ex_overflow = 0; mem_fault = '0;
    mem_pc = '0; vec_mode = 0; vec_base = '0;
    repeat (3) @(posedge clk);
    #1;
    check(flush == 4'h0 && !redirect_valid, "R1 reset outputs", 64'({flush, redirect_valid}), 64'h0);
    check(epc == 64'h0 && cause == 4'h0, "R1 reset regs", epc, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    // directed corner cases
    single(3'b110, 1'b0, 1'b0, 3'b0, 1'b1, 1, "R2 fetch priority");
    single(3'b100, 1'b0, 1'b0, 3'b0, 1'b1, 12, "R2 fetch page fault");
    single(3'b0, 1'b1, 1'b0, 3'b0, 1'b1, 2, "R3 illegal opcode");
    single(3'b0, 1'b0, 1'b1, 3'b0, 1'b1, 4, "R3 overflow");
    single(3'b0, 1'b0, 1'b0, 3'b110, 1'b1, 6, "R4 data priority");
    single(3'b0, 1'b0, 1'b0, 3'b111, 1'b1, 5, "R4 data protection first");
    single(3'b001, 1'b0, 1'b1, 3'b100, 1'b1, 0, "R6 first cause kept");
    // R11: faults raised while the stage is a bubble are dropped
    clean(5);
    step(4'b1101, 3'b0, 1'b1, 1'b0, 3'b0, 64'h300, 1'b1, 64'h0);
    step(4'hF, 3'b0, 1'b0, 1'b0, 3'b0, 64'h304, 1'b1, 64'h0);
    step(4'hF, 3'b0, 1'b0, 1'b0, 3'b0, 64'h308, 1'b1, 64'h0);
    check(!obs_rv, "R11 bubble fault ignored", 64'(obs_rv), 64'h0);
    // R5: younger decode fault one cycle before the older memory fault
    clean(5);
    step(4'hF, 3'b0, 1'b1, 1'b0, 3'b0, 64'h400, 1'b1, 64'h0);
    step(4'hF, 3'b0, 1'b0, 1'b0, 3'b001, 64'h404, 1'b1, 64'h0);
    check(obs_rv && obs_rpc == 64'd20, "R5 older wins", obs_rpc, 64'd20);
    step(4'hF, 3'b0, 1'b0, 1'b0, 3'b0, 64'h408, 1'b1, 64'h0);
    check(!obs_rv, "R8 younger flushed", 64'(obs_rv), 64'h0);
    check(epc == 64'h404, "R7 epc of older", epc, 64'h404);
    // R10 with a nonzero base
    clean(5);
    step(4'hF, 3'b0, 1'b0, 1'b0, 3'b100, 64'h500, 1'b1, 64'h8000);
    check(obs_rv && obs_rpc == 64'h8034, "R10 base plus offset", obs_rpc, 64'h8034);

    // constrained random traffic, sparse faults
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] vv;
      logic [2:0] fi, fm;
      logic fd, fe, vm;
      vv = 4'($urandom_range(0, 15)) | (($urandom_range(0, 3) != 0) ? 4'hF : 4'h0);
      fi = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b0;
      fm = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b0;
      fd = ($urandom_range(0, 9) == 0);
      fe = ($urandom_range(0, 9) == 0);
      vm = $urandom_range(0, 1) != 0;
      step(vv, fi, fd, fe, fm, {$urandom, $urandom}, vm, {$urandom, $urandom} & ~64'hFF);
    end
    @(negedge clk);
    check(epc == exp_epc, "R7 final epc", epc, exp_epc);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule